// File: doc/BRIEF.md
# Event Counter with Zero-Crossing Notification

This block keeps a bank of saturating counters, one for each counted event index. Each accepted event on the ingress lane adds one to the counter it names. A host reads each count and lowers it by a chosen amount through a small register port. Software uses it to track outstanding work items per channel and to get a signal when a channel becomes busy or drains.

Each counter watches its own boundary between zero and non-zero. When the count crosses that boundary in either direction, the counter's mapping register decides what happens. It can push an outgoing global event carrying a programmed index into a short queue that feeds the egress lane. It can instead set a programmed bit in a sticky status vector. It can also do nothing. The queue absorbs stalls on the egress lane. When the queue runs short of space, the block holds off the ingress lane and the host port, so that no notification is lost.

Host addresses are `{kind[1:0], sel}`, where `sel` selects a counter. The kinds are 0 for count (read), 1 for decrement (write), 2 for mapping (read/write) and 3 for status (read, write-1-to-clear).

Top module: `evcnt_top`

## Requirements
- R1: After reset every count is 0, every mapping register reads 0 (disabled), the status vector is 0, `eg_vld` is 0, and both `in_rdy` and `hst_rdy` are 1.
- R2: An ingress event accepted (`in_vld` and `in_rdy`) adds one to counter `in_idx`. A read with kind 0 returns that count in the low `CNT_W` bits on the same cycle.
- R3: An accepted host write with kind 1 subtracts `hst_wdata[CNT_W-1:0]` from counter `sel`. The result saturates at zero, and an amount of zero leaves the count unchanged.
- R4: Increments saturate at the all-ones value of `CNT_W` bits and never wrap.
- R5: An increment and a decrement that hit the same counter in the same cycle are combined. The raw sum count+1 is formed before the subtraction, and the result is then clamped to the range [0, max]. The zero/non-zero test uses the combined result, so 0 plus one minus one produces no notification.
- R6: When a counter goes from zero to non-zero, or from non-zero to zero, and its mapping is enabled in event mode, exactly one egress event carrying the mapped index is queued. Changes between two non-zero values, or between zero and zero, queue nothing.
- R7: The mapping register layout is: bit `DATA_W-1` enable, bit `DATA_W-2` mode (0 = egress event, 1 = status bit), and bits `[OIDX_W-1:0]` the output index. While enable is 0, a crossing changes neither the egress lane nor the status vector.
- R8: In status mode, a crossing sets status bit `index mod STAT_BITS`. The bit stays set until the host writes a 1 to it with kind 3. A set and a clear of the same bit in the same cycle leave it set. `irq_stat` shows the same vector.
- R9: Two crossings in the same cycle are queued with the lower counter index first. Egress events leave in the order they were queued.
- R10: While `eg_vld` is high and `eg_rdy` is low, `eg_vld` stays high and `eg_idx` does not change.
- R11: `in_rdy` is low while fewer than two queue entries are free, and `hst_rdy` is low while the queue is full. An ingress event or host write offered while its ready is low has no effect, and no queued event is ever lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Ingress event valid |
| in_rdy | output | 1 | Ingress event accepted when high |
| in_idx | input | $clog2(NUM_CNT) | Counter index of the ingress event |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | $clog2(NUM_CNT)+2 | Host address {kind, sel} |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data for hst_addr (combinational) |
| hst_rdy | output | 1 | Host write accepted when high |
| eg_vld | output | 1 | Egress event valid |
| eg_rdy | input | 1 | Egress lane ready |
| eg_idx | output | OIDX_W | Egress global event index |
| irq_stat | output | STAT_BITS | Sticky status vector |

## Verification
The bench builds the block with four counters of four bits, a four-entry queue, eight status bits and six-bit indices. With these values saturation is reached after fifteen increments, and the queue can be filled with a handful of crossings so that both ready signals can be driven low. The small widths also let one scoreboard queue of expected egress indices follow every crossing, including the same-cycle pairs and the combined increment-plus-decrement cases.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  // Register kind held in the two upper bits of the host address.
  typedef enum logic [1:0] {
    RK_COUNT = 2'd0,
    RK_DECR  = 2'd1,
    RK_MAP   = 2'd2,
    RK_STAT  = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/evcnt_rst_sync.sv
module evcnt_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] sh_q;

  // Asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];

endmodule

// File: rtl/evcnt_cell.sv
module evcnt_cell #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] dec_amt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             xing_o
);

  localparam logic [CNT_W-1:0] MAX_C  = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   MAX_WX = {1'b0, MAX_C};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   up_sum, net;
  logic             cnt_en;

  // Sum first, subtract next, clamp last.
  always_comb begin
    up_sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, inc_i};
    if (up_sum >= {1'b0, dec_amt_i}) net = up_sum - {1'b0, dec_amt_i};
    else                             net = '0;
    if (net > MAX_WX) cnt_d = MAX_C;
    else              cnt_d = net[CNT_W-1:0];
    cnt_en = inc_i || (dec_amt_i != '0);
    xing_o = cnt_en && ((cnt_q == '0) != (cnt_d == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_amt_i == '0 && cnt_q == MAX_C) |=> (cnt_q == MAX_C)); // R4

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_amt_i == '0 && cnt_q != MAX_C) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && dec_amt_i == '0) |=> $stable(cnt_q)); // R3

  AST_XING_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    xing_o |=> ((cnt_q == '0) != ($past(cnt_q) == '0))); // R6

endmodule

// File: rtl/evcnt_evq.sv
module evcnt_evq #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push0_i,
  input  logic [W-1:0]             data0_i,
  input  logic                     push1_i,
  input  logic [W-1:0]             data1_i,
  output logic                     out_vld_o,
  output logic [W-1:0]             out_data_o,
  input  logic                     out_rdy_i,
  output logic [$clog2(DEPTH):0]   free_o
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d, wr_nxt1;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop, q_en;

  assign out_vld_o  = (cnt_q != '0);
  assign out_data_o = mem_q[rd_q];
  assign pop        = out_vld_o && out_rdy_i;
  assign free_o     = CW'(DEPTH) - cnt_q;
  assign wr_nxt1    = wr_q + PW'(1);

  always_comb begin
    wr_d  = wr_q + PW'(push0_i) + PW'(push1_i);
    rd_d  = rd_q + PW'(pop);
    cnt_d = cnt_q + CW'(push0_i) + CW'(push1_i) - CW'(pop);
    q_en  = push0_i || push1_i || pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (q_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; occupancy guards every read.
  always_ff @(posedge clk) begin
    if (push0_i) mem_q[wr_q]    <= data0_i;
    if (push1_i) mem_q[wr_nxt1] <= data1_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((CW+1)'(cnt_q) + (CW+1)'(push0_i) + (CW+1)'(push1_i)
      <= (CW+1)'(DEPTH) + (CW+1)'(pop))); // R11

  AST_PUSH_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    push1_i |-> push0_i); // R9

  AST_EGRESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && !out_rdy_i) |=> (out_vld_o && $stable(out_data_o))); // R10

endmodule

// File: rtl/evcnt_top.sv
module evcnt_top
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT   = 16,
  parameter int CNT_W     = 16,
  parameter int OIDX_W    = 8,
  parameter int STAT_BITS = 32,
  parameter int Q_DEPTH   = 4,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_vld,
  output logic                         in_rdy,
  input  logic [$clog2(NUM_CNT)-1:0]   in_idx,
  input  logic                         hst_we,
  input  logic [$clog2(NUM_CNT)+1:0]   hst_addr,
  input  logic [DATA_W-1:0]            hst_wdata,
  output logic [DATA_W-1:0]            hst_rdata,
  output logic                         hst_rdy,
  output logic                         eg_vld,
  input  logic                         eg_rdy,
  output logic [OIDX_W-1:0]            eg_idx,
  output logic [STAT_BITS-1:0]         irq_stat
);

  localparam int CIDX_W = $clog2(NUM_CNT);
  localparam int ADDR_W = CIDX_W + 2;
  localparam int SIDX_W = $clog2(STAT_BITS);
  localparam int QC_W   = $clog2(Q_DEPTH) + 1;
  localparam int EN_BIT = DATA_W - 1;
  localparam int MD_BIT = DATA_W - 2;

  logic                  rst_n_s;
  reg_kind_e             kind;
  logic [CIDX_W-1:0]     sel;
  logic                  wr_ok;

  logic [NUM_CNT-1:0]    inc_v, xing, map_en_q, map_mode_q, map_we;
  logic [CNT_W-1:0]      dec_amt   [NUM_CNT];
  logic [CNT_W-1:0]      cnt       [NUM_CNT];
  logic [OIDX_W-1:0]     map_idx_q [NUM_CNT];

  logic                  push0, push1;
  logic [OIDX_W-1:0]     pd0, pd1;
  logic [QC_W-1:0]       q_free;

  logic [STAT_BITS-1:0]  stat_q, stat_d, stat_set, stat_clr;
  logic                  stat_en;

  evcnt_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  // Host decode
  assign kind  = reg_kind_e'(hst_addr[ADDR_W-1:CIDX_W]);
  assign sel   = hst_addr[CIDX_W-1:0];
  assign wr_ok = hst_we && hst_rdy;

  // Back-pressure: up to two crossings per cycle when both sides act
  assign in_rdy  = (q_free >= QC_W'(2));
  assign hst_rdy = (q_free >= QC_W'(1));

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    assign inc_v[gi]   = in_vld && in_rdy && (in_idx == CIDX_W'(gi));
    assign dec_amt[gi] = (wr_ok && kind == RK_DECR && sel == CIDX_W'(gi))
                         ? hst_wdata[CNT_W-1:0] : '0;
    assign map_we[gi]  = wr_ok && (kind == RK_MAP) && (sel == CIDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        map_en_q[gi]   <= 1'b0;
        map_mode_q[gi] <= 1'b0;
        map_idx_q[gi]  <= '0;
      end else if (map_we[gi]) begin
        map_en_q[gi]   <= hst_wdata[EN_BIT];
        map_mode_q[gi] <= hst_wdata[MD_BIT];
        map_idx_q[gi]  <= hst_wdata[OIDX_W-1:0];
      end
    end

    evcnt_cell #(.CNT_W(CNT_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .inc_i     (inc_v[gi]),
      .dec_amt_i (dec_amt[gi]),
      .cnt_o     (cnt[gi]),
      .xing_o    (xing[gi])
    );
  end

  // Route crossings: lowest counter index takes the first queue slot
  always_comb begin
    push0    = 1'b0;
    push1    = 1'b0;
    pd0      = '0;
    pd1      = '0;
    stat_set = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (xing[i] && map_en_q[i]) begin
        if (map_mode_q[i]) begin
          stat_set[map_idx_q[i][SIDX_W-1:0]] = 1'b1;
        end else if (!push0) begin
          push0 = 1'b1;
          pd0   = map_idx_q[i];
        end else begin
          push1 = 1'b1;
          pd1   = map_idx_q[i];
        end
      end
    end
  end

  evcnt_evq #(.W(OIDX_W), .DEPTH(Q_DEPTH)) u_q (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .push0_i    (push0),
    .data0_i    (pd0),
    .push1_i    (push1),
    .data1_i    (pd1),
    .out_vld_o  (eg_vld),
    .out_data_o (eg_idx),
    .out_rdy_i  (eg_rdy),
    .free_o     (q_free)
  );

  // Sticky status, set dominates clear
  always_comb begin
    stat_clr = (wr_ok && kind == RK_STAT) ? hst_wdata[STAT_BITS-1:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;
    stat_en  = (stat_clr != '0) || (stat_set != '0);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign irq_stat = stat_q;

  // Read mux
  always_comb begin
    hst_rdata = '0;
    unique case (kind)
      RK_COUNT: hst_rdata[CNT_W-1:0] = cnt[sel];
      RK_MAP: begin
        hst_rdata[EN_BIT]       = map_en_q[sel];
        hst_rdata[MD_BIT]       = map_mode_q[sel];
        hst_rdata[OIDX_W-1:0]   = map_idx_q[sel];
      end
      RK_STAT:  hst_rdata[STAT_BITS-1:0] = stat_q;
      default:  hst_rdata = '0;
    endcase
  end

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(wr_ok && kind == RK_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (map_en_q == '0) |-> (!push0 && stat_set == '0)); // R7

endmodule

// File: tb/tb_evcnt_top.sv
module tb_evcnt_top;

  localparam int NC   = 4;
  localparam int CW   = 4;
  localparam int OW   = 6;
  localparam int SB   = 8;
  localparam int QD   = 4;
  localparam int DW   = 32;
  localparam int CIW  = $clog2(NC);
  localparam int AW   = CIW + 2;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk, rst_n;
  logic          in_vld, in_rdy, hst_we, hst_rdy, eg_vld, eg_rdy;
  logic [CIW-1:0] in_idx;
  logic [AW-1:0] hst_addr;
  logic [DW-1:0] hst_wdata, hst_rdata;
  logic [OW-1:0] eg_idx;
  logic [SB-1:0] irq_stat;

  evcnt_top #(.NUM_CNT(NC), .CNT_W(CW), .OIDX_W(OW), .STAT_BITS(SB),
              .Q_DEPTH(QD), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_rdy(in_rdy), .in_idx(in_idx),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .hst_rdy(hst_rdy),
    .eg_vld(eg_vld), .eg_rdy(eg_rdy), .eg_idx(eg_idx),
    .irq_stat(irq_stat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk, n_bad;
  bit done;
  int exp_q[$];
  int mcnt[NC];
  bit men[NC], mmode[NC];
  int midx[NC];
  logic [SB-1:0] mstat;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pop expected egress items on every handshake
  always @(negedge clk) begin
    if (rst_n && eg_vld && eg_rdy) begin
      int e;
      if (exp_q.size() == 0) begin
        check("R6", "unexpected egress index", int'(eg_idx), -1);
      end else begin
        e = exp_q.pop_front();
        check("R9", "egress index order", int'(eg_idx), e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Reference model of one clock edge
  task automatic model_step(input bit iv, input int ii, input bit dv, input int di, input int amt);
    for (int c = 0; c < NC; c++) begin
      int old, t;
      old = mcnt[c];
      t = old + ((iv && ii == c) ? 1 : 0);
      if (dv && di == c) t = (t >= amt) ? t - amt : 0;
      if (t > CMAX) t = CMAX;
      mcnt[c] = t;
      if (((old == 0) != (t == 0)) && men[c]) begin
        if (mmode[c]) mstat[midx[c] % SB] = 1'b1;
        else          exp_q.push_back(midx[c]);
      end
    end
  endtask

  task automatic do_cycle(input bit iv, input int ii, input bit wv, input int kind,
                          input int sel, input int data);
    bit acc_in, acc_wr;
    in_vld    = iv;
    in_idx    = CIW'(ii);
    hst_we    = wv;
    hst_addr  = AW'((kind << CIW) | sel);
    hst_wdata = DW'(data);
    #1;
    acc_in = iv && in_rdy;
    acc_wr = wv && hst_rdy;
    tick();
    in_vld = 1'b0;
    hst_we = 1'b0;
    if (acc_wr && kind == 3) mstat = mstat & ~SB'(data);
    model_step(acc_in, ii, acc_wr && kind == 1, sel, data & CMAX);
    if (acc_wr && kind == 2) begin
      men[sel]   = data[31];
      mmode[sel] = data[30];
      midx[sel]  = data & ((1 << OW) - 1);
    end
  endtask

  task automatic rd_chk(input string req, input string what, input int kind,
                        input int sel, input int exp);
    hst_addr = AW'((kind << CIW) | sel);
    #3;
    check(req, what, int'(hst_rdata), exp);
  endtask

  function automatic int mapw(input bit en, input bit md, input int idx);
    return (int'(en) << 31) | (int'(md) << 30) | idx;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0; mstat = '0;
    for (int c = 0; c < NC; c++) begin
      mcnt[c] = 0; men[c] = 0; mmode[c] = 0; midx[c] = 0;
    end
    rst_n = 1'b0; in_vld = 1'b0; in_idx = '0; hst_we = 1'b0;
    hst_addr = '0; hst_wdata = '0; eg_rdy = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    check("R1", "eg_vld after reset", int'(eg_vld), 0);
    check("R1", "in_rdy after reset", int'(in_rdy), 1);
    check("R1", "hst_rdy after reset", int'(hst_rdy), 1);
    for (int c = 0; c < NC; c++) begin
      rd_chk("R1", "count after reset", 0, c, 0);
      rd_chk("R1", "map after reset", 2, c, 0);
    end
    rd_chk("R1", "status after reset", 3, 0, 0);

    // Mappings (R7 layout)
    do_cycle(0, 0, 1, 2, 0, mapw(1, 0, 5));
    do_cycle(0, 0, 1, 2, 1, mapw(1, 0, 9));
    do_cycle(0, 0, 1, 2, 2, mapw(1, 1, 3));
    do_cycle(0, 0, 1, 2, 3, mapw(0, 0, 7));
    rd_chk("R7", "map readback", 2, 2, mapw(1, 1, 3));

    // R2 / R6 increment and rise crossing
    do_cycle(1, 0, 0, 0, 0, 0);
    rd_chk("R2", "count c0 after one event", 0, 0, 1);
    do_cycle(1, 0, 0, 0, 0, 0);
    rd_chk("R2", "count c0 after two events", 0, 0, 2);
    repeat (3) tick();
    check("R6", "only one event for 0->1->2", exp_q.size(), 0);

    // R3 decrement
    do_cycle(0, 0, 1, 1, 0, 1);
    rd_chk("R3", "count after decrement 1", 0, 0, 1);
    do_cycle(0, 0, 1, 1, 0, 0);
    rd_chk("R3", "count after decrement 0", 0, 0, 1);
    do_cycle(0, 0, 1, 1, 0, 5);
    rd_chk("R3", "count saturates at zero", 0, 0, 0);
    repeat (3) tick();
    check("R6", "fall crossing delivered", exp_q.size(), 0);

    // R4 saturation
    for (int k = 0; k < CMAX + 2; k++) do_cycle(1, 1, 0, 0, 0, 0);
    rd_chk("R4", "count saturates at max", 0, 1, CMAX);
    repeat (3) tick();
    check("R4", "no event from saturation", exp_q.size(), 0);

    // R5 simultaneous increment and decrement
    do_cycle(1, 1, 1, 1, 1, CMAX);
    rd_chk("R5", "max+1-max combined", 0, 1, 1);
    do_cycle(1, 1, 1, 1, 1, 2);
    rd_chk("R5", "1+1-2 reaches zero", 0, 1, 0);
    do_cycle(1, 0, 1, 1, 0, 1);
    rd_chk("R5", "0+1-1 stays zero", 0, 0, 0);
    repeat (3) tick();
    check("R5", "crossing on net result only", exp_q.size(), 0);

    // R9 two crossings in one cycle
    do_cycle(1, 0, 0, 0, 0, 0);
    do_cycle(1, 1, 1, 1, 0, 1);
    repeat (4) tick();
    check("R9", "paired crossings drained", exp_q.size(), 0);

    // R8 status mode, W1C, set wins
    do_cycle(1, 2, 0, 0, 0, 0);
    check("R8", "irq_stat bit set", int'(irq_stat), int'(mstat));
    rd_chk("R8", "status read", 3, 0, 8);
    do_cycle(0, 0, 1, 3, 0, 8);
    rd_chk("R8", "status cleared by W1C", 3, 0, 0);
    do_cycle(0, 0, 1, 1, 2, 1);
    check("R8", "fall sets status again", int'(irq_stat), 8);
    do_cycle(1, 2, 1, 3, 0, 8);
    check("R8", "set wins over clear", int'(irq_stat), 8);
    check("R8", "status matches model", int'(irq_stat), int'(mstat));

    // R7 disabled mapping
    do_cycle(1, 3, 0, 0, 0, 0);
    repeat (3) tick();
    rd_chk("R7", "disabled counter still counts", 0, 3, 1);
    check("R7", "disabled mapping no status", int'(irq_stat), 8);
    check("R7", "disabled mapping no egress", int'(eg_vld), 0);

    // R10 / R11 back-pressure
    do_cycle(0, 0, 1, 1, 0, CMAX);
    do_cycle(0, 0, 1, 1, 1, CMAX);
    repeat (3) tick();
    eg_rdy = 1'b0;
    do_cycle(1, 0, 0, 0, 0, 0);
    do_cycle(1, 1, 0, 0, 0, 0);
    do_cycle(0, 0, 1, 1, 0, 1);
    check("R11", "in_rdy low with one free", int'(in_rdy), 0);
    check("R11", "hst_rdy high with one free", int'(hst_rdy), 1);
    check("R10", "eg_vld while stalled", int'(eg_vld), 1);
    check("R10", "eg_idx while stalled", int'(eg_idx), 5);
    tick();
    check("R10", "eg_idx held", int'(eg_idx), 5);
    do_cycle(0, 0, 1, 1, 1, 1);
    check("R11", "hst_rdy low when full", int'(hst_rdy), 0);
    do_cycle(1, 0, 0, 0, 0, 0);
    do_cycle(0, 0, 1, 2, 0, 0);
    rd_chk("R11", "refused event ignored", 0, 0, 0);
    rd_chk("R11", "refused write ignored", 2, 0, mapw(1, 0, 5));
    eg_rdy = 1'b1;
    repeat (8) tick();
    check("R11", "all queued events delivered", exp_q.size(), 0);
    check("R11", "queue empty after drain", int'(eg_vld), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule